// File: doc/BRIEF.md
# Scaled Radix-2 Butterfly Stage

This block is one pipelined radix-2 decimation-in-time butterfly for a fixed-point FFT datapath. It takes two complex samples, `a` and `b`, and a complex twiddle `w`. It multiplies `b` by `w` at full precision and reduces the product back to the data scale. It then produces the sum `x0 = a + b·w` and the difference `x1 = a − b·w`. The FFT controller drives the twiddle and a per-stage shift code. Each butterfly output is scaled by that code before it leaves the stage.

A parameter selects how the low bits are dropped. They can be truncated toward minus infinity, or rounded to nearest with ties going to the even value, which leaves no DC bias. The tie-safe rounding costs one extra pipeline register. A second parameter turns scaling off: the stage then carries the full bit growth to a wider output. In scaled mode, a sticky flag reports any result that no longer fits the output width. Clock enable and synchronous clear are each optional. The clear wins when both are active.

Top module: `bfly_r2_stage`

## Requirements
- R1: For each accepted input, `x0 = a + P` and `x1 = a − P` per real and imaginary part. `P = b·w` is a complex product in which `w` is a signed fraction with TW−1 fractional bits. The product is brought back to integer scale by dropping its TW−1 low bits. Scaled outputs are that sum or difference shifted right by the stage shift.
- R2: The product uses the same bit-dropping rule as the stage output: tie-to-even rounding when CONV=1, floor when CONV=0. With DW=16 and TW=16: 1·16384 gives 0 under both rules, 3·16384 gives 2 or 1, and −1·16384 gives 0 or −1. The reduced product always fits DW+2 signed bits.
- R3: With CONV=1, a dropped fraction above one half rounds up and one below one half rounds down. A fraction of exactly one half goes to the even neighbour. For a shift of 1: 3 → 2, 5 → 2, −3 → −2, −5 → −2.
- R4: With CONV=0, the dropped bits are discarded, which is an arithmetic shift. For a shift of 1: 3 → 1, 5 → 2, −3 → −2, −5 → −3.
- R5: The 2-bit `shift` input encodes a right shift: value 0 → 0, 1 → 1, 2 → 2, and value 3 acts as 2.
- R6: In scaled mode, a scaled result outside the signed DW-bit range still appears on the output as its low DW bits. `ovf` rises on the same edge as that output. `ovf` stays high until a clear.
- R7: With UNSCALED=1, the outputs are DW+3 bits wide and carry the exact sum and difference. `shift` has no effect and `ovf` stays low.
- R8: With USE_CLR=1, a cycle with `sclr` high empties the pipeline. After that edge `out_vld` and `ovf` are low, even if `ce` is low.
- R9: With USE_CE=1, a cycle with `ce` low changes no register: the outputs and `ovf` hold. The output sequence is the same as it would be without the stalled cycles.
- R10: `out_vld` follows `in_vld` by 4 enabled cycles with CONV=0 and by 5 enabled cycles with CONV=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sclr | input | 1 | Synchronous clear, active high (used when USE_CLR=1) |
| ce | input | 1 | Clock enable, active high (used when USE_CE=1) |
| in_vld | input | 1 | Input sample pair valid |
| a_re | input | DW | Real part of a, signed |
| a_im | input | DW | Imaginary part of a, signed |
| b_re | input | DW | Real part of b, signed |
| b_im | input | DW | Imaginary part of b, signed |
| w_re | input | TW | Real part of twiddle, signed, TW−1 fraction bits |
| w_im | input | TW | Imaginary part of twiddle, signed, TW−1 fraction bits |
| shift | input | 2 | Stage shift code (0, 1, 2; 3 acts as 2) |
| out_vld | output | 1 | Output pair valid |
| x0_re | output | DW or DW+3 | Real part of a + b·w, scaled |
| x0_im | output | DW or DW+3 | Imaginary part of a + b·w, scaled |
| x1_re | output | DW or DW+3 | Real part of a − b·w, scaled |
| x1_im | output | DW or DW+3 | Imaginary part of a − b·w, scaled |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench drives three copies of the stage in parallel: tie-to-even rounding, truncation, and unscaled. It feeds them exact half-way values, both in the product and after the stage shift. A design that rounds half away from zero, or that truncates toward zero, shows up at once on the negative ties, such as −5 or −1·16384. Shift code 3 is used next to code 2, so a decoder that shifts by 3 is caught. A full-scale sum with no shift must raise `ovf`, keep it through idle cycles, and lose it only to a clear issued while `ce` is low. That catches a flag that is not sticky, and a clear that yields to the enable. Random vectors with stalled cycles mixed in catch a pipeline stage that ignores the enable. A single-sample latency count catches a missing or extra register in either rounding variant.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  localparam int SHIFT_CODE_W = 2;
  localparam int SHIFT_MAX    = 2;

  // Stage shift code to shift amount; code 3 saturates to the largest shift.
  function automatic logic [SHIFT_CODE_W-1:0] shift_decode(input logic [SHIFT_CODE_W-1:0] code);
    return (code > SHIFT_CODE_W'(SHIFT_MAX)) ? SHIFT_CODE_W'(SHIFT_MAX) : code;
  endfunction

endpackage

// File: rtl/bfly_delay.sv
module bfly_delay #(
  parameter int W = 1,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [D];

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < D; i++) stg[i] <= '0;
    end else if (en) begin
      stg[0] <= d;
      for (int i = 1; i < D; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[D-1];

endmodule

// File: rtl/bfly_round.sv
// Drops k low bits of x, either by floor or by round-half-to-even, and
// narrows the result to OW bits, reporting whether the narrowing was exact.
module bfly_round #(
  parameter int IW   = 19,
  parameter int OW   = 16,
  parameter int KW   = 2,
  parameter int CONV = 1
) (
  input  logic signed [IW-1:0] x,
  input  logic        [KW-1:0] k,
  output logic signed [OW-1:0] y,
  output logic                 fits
);

  localparam int HW = IW - OW + 1;

  function automatic logic signed [IW-1:0] drop_bits(input logic signed [IW-1:0] v,
                                                     input logic [KW-1:0] n);
    logic [IW-1:0]        one_v;
    logic [IW-1:0]        mask;
    logic [IW-1:0]        frac;
    logic [IW-1:0]        half;
    logic signed [IW-1:0] kept;
    logic                 bump;
    one_v = {{(IW-1){1'b0}}, 1'b1};
    kept  = v >>> n;
    mask  = (one_v << n) - one_v;
    frac  = v & mask;
    half  = (n == '0) ? '0 : (one_v << (n - KW'(1)));
    bump  = (CONV != 0) && (n != '0) &&
            ((frac > half) || ((frac == half) && kept[0]));
    return kept + $signed({{(IW-1){1'b0}}, bump});
  endfunction

  logic signed [IW-1:0] full;
  logic        [HW-1:0] head;

  assign full = drop_bits(x, k);
  assign head = full[IW-1:OW-1];
  assign fits = (&head) | ~(|head);
  assign y    = full[OW-1:0];

endmodule

// File: rtl/bfly_cmul.sv
// Two-stage complex multiply: full-precision partial products, then the
// combined product reduced by TW-1 fraction bits to DW+2 bits.
module bfly_cmul #(
  parameter int DW   = 16,
  parameter int TW   = 16,
  parameter int CONV = 1
) (
  input  logic                 clk,
  input  logic                 en,
  input  logic                 clr,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  input  logic signed [TW-1:0] w_re,
  input  logic signed [TW-1:0] w_im,
  output logic signed [DW+1:0] p_re,
  output logic signed [DW+1:0] p_im,
  output logic                 p_fit
);

  localparam int MW = DW + TW;
  localparam int FW = MW + 1;
  localparam int PW = DW + 2;
  localparam int KW = $clog2(TW) + 1;

  logic signed [MW-1:0] pp_rr, pp_ii, pp_ri, pp_ir;
  logic signed [FW-1:0] sum_re, sum_im;
  logic signed [PW-1:0] red_re, red_im;
  logic                 fit_re, fit_im;

  always_ff @(posedge clk) begin
    if (clr) begin
      pp_rr <= '0;
      pp_ii <= '0;
      pp_ri <= '0;
      pp_ir <= '0;
    end else if (en) begin
      pp_rr <= MW'(b_re) * MW'(w_re);
      pp_ii <= MW'(b_im) * MW'(w_im);
      pp_ri <= MW'(b_re) * MW'(w_im);
      pp_ir <= MW'(b_im) * MW'(w_re);
    end
  end

  assign sum_re = FW'(pp_rr) - FW'(pp_ii);
  assign sum_im = FW'(pp_ri) + FW'(pp_ir);

  bfly_round #(.IW(FW), .OW(PW), .KW(KW), .CONV(CONV)) u_red_re (
    .x(sum_re), .k(KW'(TW - 1)), .y(red_re), .fits(fit_re)
  );

  bfly_round #(.IW(FW), .OW(PW), .KW(KW), .CONV(CONV)) u_red_im (
    .x(sum_im), .k(KW'(TW - 1)), .y(red_im), .fits(fit_im)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      p_re  <= '0;
      p_im  <= '0;
      p_fit <= 1'b1;
    end else if (en) begin
      p_re  <= red_re;
      p_im  <= red_im;
      p_fit <= fit_re & fit_im;
    end
  end

endmodule

// File: rtl/bfly_r2_stage.sv
module bfly_r2_stage #(
  parameter int DW       = 16,
  parameter int TW       = 16,
  parameter int CONV     = 1,
  parameter int UNSCALED = 0,
  parameter int USE_CE   = 1,
  parameter int USE_CLR  = 1
) (
  input  logic                                      clk,
  input  logic                                      sclr,
  input  logic                                      ce,
  input  logic                                      in_vld,
  input  logic signed [DW-1:0]                      a_re,
  input  logic signed [DW-1:0]                      a_im,
  input  logic signed [DW-1:0]                      b_re,
  input  logic signed [DW-1:0]                      b_im,
  input  logic signed [TW-1:0]                      w_re,
  input  logic signed [TW-1:0]                      w_im,
  input  logic        [1:0]                         shift,
  output logic                                      out_vld,
  output logic signed [(UNSCALED ? DW+3 : DW)-1:0]  x0_re,
  output logic signed [(UNSCALED ? DW+3 : DW)-1:0]  x0_im,
  output logic signed [(UNSCALED ? DW+3 : DW)-1:0]  x1_re,
  output logic signed [(UNSCALED ? DW+3 : DW)-1:0]  x1_im,
  output logic                                      ovf
);

  import bfly_pkg::*;

  localparam int PW   = DW + 2;
  localparam int SW   = DW + 3;
  localparam int OW   = UNSCALED ? SW : DW;
  localparam int TAIL = (CONV != 0) ? 2 : 1;
  localparam int LAT  = 3 + TAIL;
  localparam int CW   = SHIFT_CODE_W;

  // Effective controls, brought out for the checker.
  logic en_eff, clr_eff;
  assign en_eff  = (USE_CE  != 0) ? ce   : 1'b1;
  assign clr_eff = (USE_CLR != 0) ? sclr : 1'b0;

  // Stage 1: input registers.
  logic signed [DW-1:0] a1_re, a1_im, b1_re, b1_im;
  logic signed [TW-1:0] w1_re, w1_im;
  logic        [CW-1:0] sh1;
  logic                 v1;

  always_ff @(posedge clk) begin
    if (clr_eff) begin
      a1_re <= '0; a1_im <= '0; b1_re <= '0; b1_im <= '0;
      w1_re <= '0; w1_im <= '0; sh1 <= '0; v1 <= 1'b0;
    end else if (en_eff) begin
      a1_re <= a_re; a1_im <= a_im; b1_re <= b_re; b1_im <= b_im;
      w1_re <= w_re; w1_im <= w_im; sh1 <= shift; v1 <= in_vld;
    end
  end

  // Stages 2-3: twiddle product, with a, shift and valid delayed alongside.
  logic signed [PW-1:0] p3_re, p3_im;
  logic                 prod_fit;

  bfly_cmul #(.DW(DW), .TW(TW), .CONV(CONV)) u_cmul (
    .clk(clk), .en(en_eff), .clr(clr_eff),
    .b_re(b1_re), .b_im(b1_im), .w_re(w1_re), .w_im(w1_im),
    .p_re(p3_re), .p_im(p3_im), .p_fit(prod_fit)
  );

  logic [2*DW+CW:0] side1, side3;
  assign side1 = {a1_re, a1_im, sh1, v1};

  bfly_delay #(.W(2*DW+CW+1), .D(2)) u_side (
    .clk(clk), .en(en_eff), .clr(clr_eff), .d(side1), .q(side3)
  );

  logic signed [DW-1:0] a3_re, a3_im;
  logic        [CW-1:0] sh3;
  logic                 v3;
  assign {a3_re, a3_im, sh3, v3} = side3;

  // Butterfly add/subtract at full growth: index 0 x0_re, 1 x0_im, 2 x1_re, 3 x1_im.
  logic [3:0][SW-1:0] bf3;
  assign bf3[0] = SW'(a3_re) + SW'(p3_re);
  assign bf3[1] = SW'(a3_im) + SW'(p3_im);
  assign bf3[2] = SW'(a3_re) - SW'(p3_re);
  assign bf3[3] = SW'(a3_im) - SW'(p3_im);

  // Scaling input: one extra register when rounding, to keep logic depth.
  logic [3:0][SW-1:0] sc_in;
  logic [CW-1:0]      sc_sh;
  logic               sc_v;

  generate
    if (CONV != 0) begin : g_tail_reg
      logic [4*SW+CW:0] tail_q;
      bfly_delay #(.W(4*SW+CW+1), .D(1)) u_tail (
        .clk(clk), .en(en_eff), .clr(clr_eff),
        .d({bf3, sh3, v3}), .q(tail_q)
      );
      assign {sc_in, sc_sh, sc_v} = tail_q;
    end else begin : g_tail_comb
      assign sc_in = bf3;
      assign sc_sh = sh3;
      assign sc_v  = v3;
    end
  endgenerate

  // Per-component scaling and range check.
  logic [3:0][OW-1:0] sc_out;
  logic [3:0]         sc_fit;
  logic [CW-1:0]      sc_amt;
  assign sc_amt = shift_decode(sc_sh);

  generate
    for (genvar g = 0; g < 4; g++) begin : g_scale
      if (UNSCALED != 0) begin : g_full
        assign sc_out[g] = sc_in[g];
        assign sc_fit[g] = 1'b1;
      end else begin : g_shift
        logic signed [OW-1:0] y_s;
        bfly_round #(.IW(SW), .OW(OW), .KW(CW), .CONV(CONV)) u_scale (
          .x($signed(sc_in[g])), .k(sc_amt), .y(y_s), .fits(sc_fit[g])
        );
        assign sc_out[g] = y_s;
      end
    end
  endgenerate

  logic ovf_evt;
  assign ovf_evt = sc_v & ~(&sc_fit);

  // Output stage.
  always_ff @(posedge clk) begin
    if (clr_eff) begin
      out_vld <= 1'b0;
      x0_re   <= '0;
      x0_im   <= '0;
      x1_re   <= '0;
      x1_im   <= '0;
      ovf     <= 1'b0;
    end else if (en_eff) begin
      out_vld <= sc_v;
      x0_re   <= sc_out[0];
      x0_im   <= sc_out[1];
      x1_re   <= sc_out[2];
      x1_im   <= sc_out[3];
      ovf     <= ovf | ovf_evt;
    end
  end

endmodule

// File: rtl/bfly_r2_chk.sv
module bfly_r2_chk #(
  parameter int LAT = 5,
  parameter int OW  = 16
) (
  input logic          clk,
  input logic          clr_eff,
  input logic          en_eff,
  input logic          in_vld,
  input logic          out_vld,
  input logic          ovf,
  input logic          ovf_evt,
  input logic          prod_fit,
  input logic [OW-1:0] x0_re,
  input logic [OW-1:0] x1_im
);

  logic           armed = 1'b0;
  logic [LAT-1:0] vtrack;

  always_ff @(posedge clk) begin
    if (clr_eff) armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (clr_eff)     vtrack <= '0;
    else if (en_eff) vtrack <= {vtrack[LAT-2:0], in_vld};
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (clr_eff || !armed)
    out_vld == vtrack[LAT-1]); // R10

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (clr_eff || !armed)
    ovf |=> ovf); // R6

  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (clr_eff || !armed)
    $rose(ovf) |-> $past(ovf_evt && en_eff)); // R6

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!armed)
    clr_eff |=> (!out_vld && !ovf)); // R8

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (clr_eff || !armed)
    !en_eff |=> ($stable(out_vld) && $stable(ovf) && $stable(x0_re) && $stable(x1_im))); // R9

  AST_PRODUCT_FITS: assert property (@(posedge clk) disable iff (clr_eff || !armed)
    prod_fit); // R2

endmodule

bind bfly_r2_stage bfly_r2_chk #(.LAT(LAT), .OW(OW)) u_chk (
  .clk(clk), .clr_eff(clr_eff), .en_eff(en_eff), .in_vld(in_vld),
  .out_vld(out_vld), .ovf(ovf), .ovf_evt(ovf_evt), .prod_fit(prod_fit),
  .x0_re(x0_re), .x1_im(x1_im)
);

// File: tb/tb_bfly_r2_stage.sv
module tb_bfly_r2_stage;

  localparam int DW = 16;
  localparam int TW = 16;
  localparam int UW = DW + 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                 sclr = 1'b1;
  logic                 ce = 1'b1;
  logic                 in_vld = 1'b0;
  logic signed [DW-1:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic signed [TW-1:0] w_re = '0, w_im = '0;
  logic        [1:0]    shift = '0;

  logic                 cv_vld, tr_vld, un_vld, cv_ovf, tr_ovf, un_ovf;
  logic signed [DW-1:0] cv0r, cv0i, cv1r, cv1i, tr0r, tr0i, tr1r, tr1i;
  logic signed [UW-1:0] un0r, un0i, un1r, un1i;

  bfly_r2_stage #(.DW(DW), .TW(TW), .CONV(1), .UNSCALED(0)) dut (
    .clk(clk), .sclr(sclr), .ce(ce), .in_vld(in_vld),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im), .w_re(w_re), .w_im(w_im),
    .shift(shift), .out_vld(cv_vld), .x0_re(cv0r), .x0_im(cv0i), .x1_re(cv1r),
    .x1_im(cv1i), .ovf(cv_ovf)
  );

  bfly_r2_stage #(.DW(DW), .TW(TW), .CONV(0), .UNSCALED(0)) dut_tr (
    .clk(clk), .sclr(sclr), .ce(ce), .in_vld(in_vld),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im), .w_re(w_re), .w_im(w_im),
    .shift(shift), .out_vld(tr_vld), .x0_re(tr0r), .x0_im(tr0i), .x1_re(tr1r),
    .x1_im(tr1i), .ovf(tr_ovf)
  );

  bfly_r2_stage #(.DW(DW), .TW(TW), .CONV(1), .UNSCALED(1)) dut_un (
    .clk(clk), .sclr(sclr), .ce(ce), .in_vld(in_vld),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im), .w_re(w_re), .w_im(w_im),
    .shift(shift), .out_vld(un_vld), .x0_re(un0r), .x0_im(un0i), .x1_re(un1r),
    .x1_im(un1i), .ovf(un_ovf)
  );

  typedef struct {
    longint o[4];
    bit     ov;
    string  req;
  } exp_t;

  exp_t q_cv[$];
  exp_t q_tr[$];
  exp_t q_un[$];

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Reference reduction: floor of x / 2^k, then bump on ties-to-even if asked.
  function automatic longint drop_ref(input longint x, input int k, input bit conv);
    longint p2, q, r;
    if (k == 0) return x;
    p2 = longint'(1) <<< k;
    q  = x >>> k;
    r  = x - q * p2;
    if (conv && ((r > p2 / 2) || ((r == p2 / 2) && (q % 2 != 0)))) q = q + 1;
    return q;
  endfunction

  function automatic longint wrap_to(input longint v, input int w);
    longint m, r;
    m = longint'(1) <<< w;
    r = v & (m - 1);
    if (r >= m / 2) r = r - m;
    return r;
  endfunction

  function automatic exp_t model(input longint s[4], input int k, input bit conv,
                                 input bit unscaled, input string req);
    exp_t e;
    e.ov  = 1'b0;
    e.req = req;
    for (int i = 0; i < 4; i++) begin
      if (unscaled) begin
        e.o[i] = s[i];
      end else begin
        longint r;
        r = drop_ref(s[i], k, conv);
        if (r > 32767 || r < -32768) e.ov = 1'b1;
        e.o[i] = wrap_to(r, DW);
      end
    end
    return e;
  endfunction

  // Driver: computes expected results for all three variants, then applies the sample.
  task automatic drive(input longint ar, ai, br, bi, wr, wi, input int sh,
                       input bit stall, input string req);
    longint s_c[4], s_t[4];
    longint pc_re, pc_im, pt_re, pt_im;
    int k;
    k = (sh == 3) ? 2 : sh;
    pc_re = drop_ref(br * wr - bi * wi, TW - 1, 1'b1);
    pc_im = drop_ref(br * wi + bi * wr, TW - 1, 1'b1);
    pt_re = drop_ref(br * wr - bi * wi, TW - 1, 1'b0);
    pt_im = drop_ref(br * wi + bi * wr, TW - 1, 1'b0);
    s_c[0] = ar + pc_re; s_c[1] = ai + pc_im; s_c[2] = ar - pc_re; s_c[3] = ai - pc_im;
    s_t[0] = ar + pt_re; s_t[1] = ai + pt_im; s_t[2] = ar - pt_re; s_t[3] = ai - pt_im;
    q_cv.push_back(model(s_c, k, 1'b1, 1'b0, req));
    q_tr.push_back(model(s_t, k, 1'b0, 1'b0, req));
    q_un.push_back(model(s_c, k, 1'b1, 1'b1, req));
    a_re = DW'(ar); a_im = DW'(ai); b_re = DW'(br); b_im = DW'(bi);
    w_re = TW'(wr); w_im = TW'(wi); shift = 2'(sh); in_vld = 1'b1;
    if (stall) begin
      ce = 1'b0;
      @(posedge clk); #2;
    end
    ce = 1'b1;
    @(posedge clk); #2;
    in_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic do_clear(input bit ce_v);
    sclr = 1'b1;
    ce = ce_v;
    @(posedge clk); #2;
    sclr = 1'b0;
    ce = 1'b1;
  endtask

  // Monitor: pops expected items as each variant produces results.
  bit     ce_seen = 1'b1, clr_seen = 1'b1;
  bit     eo_cv = 1'b0, eo_tr = 1'b0;
  logic   last_vld = 1'b0;
  longint last_x0 = 0;

  task automatic compare(input string tag, inout exp_t q[$], input longint a0, a1, a2, a3,
                         output bit ov);
    exp_t e;
    longint act[4];
    act[0] = a0; act[1] = a1; act[2] = a2; act[3] = a3;
    ov = 1'b0;
    if (q.size() == 0) begin
      check(1'b0, "R1", {tag, " unexpected output"}, 1, 0);
      return;
    end
    e = q.pop_front();
    ov = e.ov;
    for (int i = 0; i < 4; i++)
      check(act[i] == e.o[i], e.req, $sformatf("%s component %0d", tag, i), act[i], e.o[i]);
  endtask

  initial begin : monitor
    bit ov;
    forever begin
      @(negedge clk);
      if (clr_seen) begin
        eo_cv = 1'b0;
        eo_tr = 1'b0;
        check(!cv_vld && !tr_vld && !un_vld, "R8", "valid after clear", cv_vld, 0);
      end else if (!ce_seen) begin
        check(cv_vld == last_vld && longint'(cv0r) == last_x0, "R9", "hold during stall",
              longint'(cv0r), last_x0);
      end else begin
        if (cv_vld) begin
          compare("conv", q_cv, cv0r, cv0i, cv1r, cv1i, ov);
          eo_cv = eo_cv | ov;
        end
        if (tr_vld) begin
          compare("trunc", q_tr, tr0r, tr0i, tr1r, tr1i, ov);
          eo_tr = eo_tr | ov;
        end
        if (un_vld) compare("unscaled", q_un, un0r, un0i, un1r, un1i, ov);
      end
      check(cv_ovf == eo_cv, "R6", "conv ovf", cv_ovf, eo_cv);
      check(tr_ovf == eo_tr, "R6", "trunc ovf", tr_ovf, eo_tr);
      check(un_ovf == 1'b0, "R7", "unscaled ovf", un_ovf, 0);
      last_vld = cv_vld;
      last_x0  = cv0r;
      ce_seen  = ce;
      clr_seen = sclr;
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin : main
    int t_tr, t_cv;
    idle(2);
    sclr = 1'b0;
    idle(1);
    // R8: state after clear.
    check(!cv_vld && !cv_ovf && !tr_vld && !un_vld, "R8", "reset state", cv_vld, 0);

    // R10: latency of a single sample.
    t_tr = 0; t_cv = 0;
    drive(100, -7, 3, 2, 16384, -16384, 1, 1'b0, "R1");
    for (int c = 1; c <= 7; c++) begin
      @(negedge clk);
      if (tr_vld && t_tr == 0) t_tr = c;
      if (cv_vld && t_cv == 0) t_cv = c;
    end
    #2;
    check(t_tr == 4, "R10", "truncation latency", t_tr, 4);
    check(t_cv == 5, "R10", "convergent latency", t_cv, 5);

    // R3 / R4: output ties with zero twiddle (product 0).
    drive(3, -3, 0, 0, 0, 0, 1, 1'b0, "R3");
    drive(5, -5, 0, 0, 0, 0, 1, 1'b0, "R4");
    drive(6, 10, 0, 0, 0, 0, 2, 1'b0, "R3");
    drive(9, 11, 0, 0, 0, 0, 2, 1'b0, "R3");
    drive(-6, -10, 0, 0, 0, 0, 2, 1'b0, "R4");
    // R5: shift code 3 acts as 2; code 0 passes through.
    drive(10, -10, 0, 0, 0, 0, 3, 1'b0, "R5");
    drive(1234, -4321, 0, 0, 0, 0, 0, 1'b0, "R5");
    // R2: product ties.
    drive(0, 0, 1, 0, 16384, 0, 0, 1'b0, "R2");
    drive(0, 0, 3, 0, 16384, 0, 0, 1'b0, "R2");
    drive(0, 0, -1, 0, 16384, 0, 0, 1'b0, "R2");
    drive(0, 0, 0, 5, 16384, 16384, 0, 1'b0, "R2");
    // R1: full-scale corners without overflow.
    drive(-32768, -32768, -32768, -32768, -32768, -32768, 2, 1'b0, "R1");
    drive(32767, -32768, 32767, 32767, 32767, -32768, 2, 1'b0, "R1");
    idle(8);

    // R9: random vectors with stalls mixed in.
    for (int n = 0; n < 60; n++) begin
      longint r[6];
      for (int j = 0; j < 6; j++) r[j] = longint'($signed(16'($urandom())));
      drive(r[0], r[1], r[2], r[3], r[4], r[5], 1 + int'($urandom() % 3), (n % 5) == 2, "R9");
    end
    idle(10);

    // R6: overflow, sticky through idle and a benign sample.
    drive(32767, 0, 32767, 0, 32767, 0, 0, 1'b0, "R6");
    idle(8);
    check(cv_ovf == 1'b1, "R6", "ovf raised", cv_ovf, 1);
    drive(1, 1, 0, 0, 0, 0, 1, 1'b0, "R6");
    idle(8);
    check(cv_ovf == 1'b1 && tr_ovf == 1'b1, "R6", "ovf sticky", cv_ovf, 1);
    // R7: unscaled output of the same kind of sample is exact.
    drive(-32768, 32767, -32768, 32767, 32767, 32767, 0, 1'b0, "R7");
    idle(8);

    // R8: clear with ce low still wins.
    do_clear(1'b0);
    @(negedge clk);
    check(cv_ovf == 1'b0 && tr_ovf == 1'b0, "R8", "clear beats ce", cv_ovf, 0);
    #2;
    drive(7, 7, 0, 0, 0, 0, 1, 1'b0, "R8");
    idle(8);

    check(q_cv.size() == 0, "R1", "conv queue drained", q_cv.size(), 0);
    check(q_tr.size() == 0, "R4", "trunc queue drained", q_tr.size(), 0);
    check(q_un.size() == 0, "R7", "unscaled queue drained", q_un.size(), 0);
    finish_run();
  end

endmodule